// File: doc/BRIEF.md
# Single-Entry Relocation Network

This block is a purely combinational permutation stage for a table of fixed-width integer entries. A caller names one entry by its index, gives a distance and a direction, and receives the table with that entry pulled out and reinserted at its new position. The entries it passes over each shift by one place toward the vacated slot. Every entry outside the crossed span keeps its place. Unlike a rotate of the whole vector, only the chosen entry and the stretch it crosses are rearranged.

The default configuration holds 54 entries of 6 bits each, packed with entry i at bits [i*6 +: 6]. When the requested destination falls off either end of the table, or the source index itself does not exist, the block flags the request as out of range and returns the table untouched. It has no clock and no state. The outputs settle from the inputs alone.

Top module: `pmove_net`

## Requirements
- R1: When move_dist is 0 and src_idx is below 54, ent_out equals ent_in and out_of_range is 0.
- R2: With move_down = 0 the destination is d = src_idx + move_dist. If d <= 53, the output entry at d is the input entry at src_idx, and for every i with src_idx <= i < d the output entry at i is the input entry at i+1.
- R3: With move_down = 1 the destination is d = src_idx - move_dist. If d >= 0, the output entry at d is the input entry at src_idx, and for every i with d < i <= src_idx the output entry at i is the input entry at i-1.
- R4: Every output entry whose index lies outside the closed range between src_idx and the destination equals the input entry at the same index.
- R5: out_of_range is 1 exactly when src_idx > 53, or when move_down = 0 and src_idx + move_dist > 53, or when move_down = 1 and move_dist > src_idx. Whenever it is 1, ent_out equals ent_in.
- R6: Exactly one output lane receives the relocated entry during a nonzero in-range move, and no lane receives it otherwise.
- R7: The block has no storage: a change on ent_in alone, with no clock activity, shows on ent_out within the same time step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ent_in | input | 324 | Packed input table; entry i at bits [i*6 +: 6] |
| src_idx | input | 6 | Index of the entry to relocate |
| move_dist | input | 6 | Number of positions to move it |
| move_down | input | 1 | 0 moves toward higher indices, 1 toward lower indices |
| ent_out | output | 324 | Permuted table, same packing as ent_in |
| out_of_range | output | 1 | Request rejected; ent_out mirrors ent_in |

## Verification
The bench goes after the span edges. At a span edge, a design with an off-by-one in its comparisons would duplicate one neighbour and lose another, or would leave the source slot holding a stale copy. It drives moves that land exactly on index 0 and index 53, and moves one step past them. An error in the range test there would either wrap the entry around the table or corrupt it instead of returning it intact. It also drives source indices 54 to 63 and the zero distance. The first catches a design that reads a nonexistent entry. The second catches a design that shifts a neighbour when nothing should move. Every source, distance and direction combination is compared against a model that carries the entry one adjacent swap at a time. A lane that took its left neighbour where it should have taken its right one therefore shows up under random data.

// File: rtl/pmove_pkg.sv
package pmove_pkg;

  // Source chosen by one output lane of the relocation network.
  typedef enum logic [1:0] {
    SEL_KEEP  = 2'd0,   // own input entry
    SEL_NEXT  = 2'd1,   // entry one index higher (upward move span)
    SEL_PREV  = 2'd2,   // entry one index lower (downward move span)
    SEL_MOVED = 2'd3    // the relocated entry (destination lane)
  } lane_sel_e;

endpackage

// File: rtl/pmove_span_decode.sv
module pmove_span_decode #(
  parameter int N_ENT = 54,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] move_dist,
  input  logic             move_down,
  output logic [IDX_W-1:0] dst_idx,
  output logic             out_of_range,
  output logic             move_active
);

  localparam logic [IDX_W:0] LAST = (IDX_W+1)'(N_ENT - 1);

  // Far end of the move, one bit wider so an upward overflow stays visible.
  function automatic logic [IDX_W:0] far_end(input logic [IDX_W-1:0] s,
                                             input logic [IDX_W-1:0] d,
                                             input logic             dn);
    if (dn) return {1'b0, s} - {1'b0, d};
    else    return {1'b0, s} + {1'b0, d};
  endfunction

  // True when the move leaves the table or starts from a missing entry.
  function automatic logic leaves_table(input logic [IDX_W-1:0] s,
                                        input logic [IDX_W-1:0] d,
                                        input logic             dn,
                                        input logic [IDX_W:0]   reach);
    if ({1'b0, s} > LAST) return 1'b1;
    if (dn)               return d > s;
    return reach > LAST;
  endfunction

  logic [IDX_W:0] reach;

  always_comb begin
    reach        = far_end(src_idx, move_dist, move_down);
    dst_idx      = reach[IDX_W-1:0];
    out_of_range = leaves_table(src_idx, move_dist, move_down, reach);
    move_active  = !out_of_range && (move_dist != '0);
  end

  // R5: an accepted request never names a destination outside the table.
  always_comb begin
    if (!out_of_range)
      a_r5_dst_inside: assert ({1'b0, dst_idx} <= LAST)
        else $error("R5: accepted move has destination %0d", dst_idx);
  end

endmodule

// File: rtl/pmove_lane.sv
module pmove_lane
  import pmove_pkg::*;
#(
  parameter int ENT_W = 6,
  parameter int IDX_W = 6,
  parameter int POS   = 0
) (
  input  logic [ENT_W-1:0] self_ent,
  input  logic [ENT_W-1:0] next_ent,
  input  logic [ENT_W-1:0] prev_ent,
  input  logic [ENT_W-1:0] moved_ent,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             move_down,
  input  logic             move_active,
  output logic [ENT_W-1:0] lane_out,
  output logic             lane_is_dst
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(POS);

  logic      take_next;
  logic      take_prev;
  lane_sel_e sel;

  always_comb begin
    lane_is_dst = move_active && (dst_idx == MY_IDX);
    take_next   = move_active && !move_down && (MY_IDX >= src_idx) && (MY_IDX < dst_idx);
    take_prev   = move_active &&  move_down && (MY_IDX >  dst_idx) && (MY_IDX <= src_idx);

    if (lane_is_dst)    sel = SEL_MOVED;
    else if (take_next) sel = SEL_NEXT;
    else if (take_prev) sel = SEL_PREV;
    else                sel = SEL_KEEP;

    case (sel)
      SEL_NEXT:  lane_out = next_ent;
      SEL_PREV:  lane_out = prev_ent;
      SEL_MOVED: lane_out = moved_ent;
      default:   lane_out = self_ent;
    endcase
  end

  // R4: a lane is never both the landing slot and a sliding neighbour.
  always_comb begin
    a_r4_lane_exclusive: assert ($onehot0({lane_is_dst, take_next, take_prev}))
      else $error("R4: lane %0d has overlapping selects", POS);
  end

endmodule

// File: rtl/pmove_net.sv
module pmove_net #(
  parameter int N_ENT = 54,
  parameter int ENT_W = 6,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int VEC_W = N_ENT * ENT_W
) (
  input  logic [VEC_W-1:0] ent_in,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] move_dist,
  input  logic             move_down,
  output logic [VEC_W-1:0] ent_out,
  output logic             out_of_range
);

  logic [ENT_W-1:0] in_arr  [N_ENT];
  logic [ENT_W-1:0] out_arr [N_ENT];
  logic [N_ENT-1:0] dst_hit;
  logic [ENT_W-1:0] moved_ent;
  logic [IDX_W-1:0] dst_idx;
  logic             move_active;

  pmove_span_decode #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_decode (
    .src_idx      (src_idx),
    .move_dist    (move_dist),
    .move_down    (move_down),
    .dst_idx      (dst_idx),
    .out_of_range (out_of_range),
    .move_active  (move_active)
  );

  // Single shared selector for the entry being relocated.
  always_comb begin
    moved_ent = '0;
    for (int k = 0; k < N_ENT; k++)
      if (src_idx == IDX_W'(k)) moved_ent = in_arr[k];
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_lane
    logic [ENT_W-1:0] nb_next;
    logic [ENT_W-1:0] nb_prev;

    assign in_arr[i]                 = ent_in[i*ENT_W +: ENT_W];
    assign ent_out[i*ENT_W +: ENT_W] = out_arr[i];

    if (i == N_ENT - 1) begin : g_top_edge
      assign nb_next = '0;
    end else begin : g_next
      assign nb_next = ent_in[(i+1)*ENT_W +: ENT_W];
    end

    if (i == 0) begin : g_bot_edge
      assign nb_prev = '0;
    end else begin : g_prev
      assign nb_prev = ent_in[(i-1)*ENT_W +: ENT_W];
    end

    pmove_lane #(.ENT_W(ENT_W), .IDX_W(IDX_W), .POS(i)) u_lane (
      .self_ent    (in_arr[i]),
      .next_ent    (nb_next),
      .prev_ent    (nb_prev),
      .moved_ent   (moved_ent),
      .src_idx     (src_idx),
      .dst_idx     (dst_idx),
      .move_down   (move_down),
      .move_active (move_active),
      .lane_out    (out_arr[i]),
      .lane_is_dst (dst_hit[i])
    );
  end

  always_comb begin
    // R5: a rejected request passes the table straight through.
    if (out_of_range)
      a_r5_reject_passthru: assert (ent_out == ent_in)
        else $error("R5: rejected move altered the table");
    // R1: zero distance is an identity.
    if (!out_of_range && move_dist == '0)
      a_r1_zero_identity: assert (ent_out == ent_in)
        else $error("R1: zero-distance move altered the table");
    // R6: landing slot count follows the decode.
    a_r6_single_landing: assert ($countones(dst_hit) == (move_active ? 1 : 0))
      else $error("R6: %0d lanes claim the relocated entry", $countones(dst_hit));
    // R2/R3: the landing lane carries the source entry.
    if (move_active)
      a_r2_landing_value: assert (out_arr[dst_idx] == in_arr[src_idx])
        else $error("R2: landing lane %0d holds the wrong entry", dst_idx);
  end

endmodule

// File: tb/tb_pmove_net.sv
module tb_pmove_net;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 54;
  localparam int EW = 6;
  localparam int IW = 6;
  localparam int NT = 14;

  // {src, dist, down, probe index, expected probe value, expected flag}
  localparam logic [25:0] TBL [NT] = '{
    {6'd1,  6'd3,  1'b0, 6'd4,  6'd1,  1'b0},
    {6'd1,  6'd3,  1'b0, 6'd1,  6'd2,  1'b0},
    {6'd5,  6'd3,  1'b1, 6'd2,  6'd5,  1'b0},
    {6'd5,  6'd3,  1'b1, 6'd5,  6'd4,  1'b0},
    {6'd0,  6'd53, 1'b0, 6'd53, 6'd0,  1'b0},
    {6'd0,  6'd53, 1'b0, 6'd0,  6'd1,  1'b0},
    {6'd53, 6'd53, 1'b1, 6'd0,  6'd53, 1'b0},
    {6'd53, 6'd53, 1'b1, 6'd53, 6'd52, 1'b0},
    {6'd53, 6'd1,  1'b0, 6'd53, 6'd53, 1'b1},
    {6'd0,  6'd1,  1'b1, 6'd0,  6'd0,  1'b1},
    {6'd60, 6'd0,  1'b0, 6'd10, 6'd10, 1'b1},
    {6'd20, 6'd0,  1'b1, 6'd20, 6'd20, 1'b0},
    {6'd20, 6'd33, 1'b0, 6'd53, 6'd20, 1'b0},
    {6'd20, 6'd34, 1'b0, 6'd53, 6'd53, 1'b1}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*EW-1:0] ent_in = '0;
  logic [IW-1:0]  src_idx = '0;
  logic [IW-1:0]  move_dist = '0;
  logic           move_down = 1'b0;
  logic [N*EW-1:0] ent_out;
  logic           out_of_range;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pmove_net dut (
    .ent_in       (ent_in),
    .src_idx      (src_idx),
    .move_dist    (move_dist),
    .move_down    (move_down),
    .ent_out      (ent_out),
    .out_of_range (out_of_range)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model: reject check, then carry the entry by successive adjacent swaps.
  task automatic model(input logic [N*EW-1:0] vin, input int s, input int d,
                       input bit dn, output logic [N*EW-1:0] vout, output bit bad);
    logic [EW-1:0] a [N];
    logic [EW-1:0] t;
    int p;
    bad = (s >= N) || (!dn && s + d >= N) || (dn && d > s);
    vout = vin;
    if (bad) return;
    for (int k = 0; k < N; k++) a[k] = vin[k*EW +: EW];
    p = s;
    for (int k = 0; k < d; k++) begin
      if (dn) begin t = a[p-1]; a[p-1] = a[p]; a[p] = t; p = p - 1; end
      else    begin t = a[p+1]; a[p+1] = a[p]; a[p] = t; p = p + 1; end
    end
    for (int k = 0; k < N; k++) vout[k*EW +: EW] = a[k];
  endtask

  task automatic check_vec(input string tag, input logic [N*EW-1:0] exp_v, input bit exp_f);
    checks++;
    if (ent_out !== exp_v || out_of_range !== exp_f) begin
      errors++;
      $display("FAIL %s: src=%0d dist=%0d down=%0d out=%h flag=%0b expected out=%h flag=%0b",
               tag, src_idx, move_dist, move_down, ent_out, out_of_range, exp_v, exp_f);
    end
  endtask

  task automatic apply(input logic [N*EW-1:0] v, input int s, input int d, input bit dn);
    @(posedge clk);
    ent_in    = v;
    src_idx   = IW'(s);
    move_dist = IW'(d);
    move_down = dn;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [N*EW-1:0] ramp;
    logic [N*EW-1:0] rnd;
    logic [N*EW-1:0] exp_v;
    bit exp_f;

    for (int k = 0; k < N; k++) ramp[k*EW +: EW] = EW'(k);

    // Reset state: all-zero stimulus gives all-zero table, no flag (R1).
    repeat (2) @(posedge clk);
    #2;
    check_vec("R1 reset", '0, 1'b0);
    rst = 1'b0;

    // Directed table on a ramp pattern (R2, R3, R5).
    for (int t = 0; t < NT; t++) begin
      apply(ramp, int'(TBL[t][25:20]), int'(TBL[t][19:14]), TBL[t][13]);
      checks++;
      if (ent_out[TBL[t][12:7]*EW +: EW] !== TBL[t][6:1] || out_of_range !== TBL[t][0]) begin
        errors++;
        $display("FAIL R2/R3/R5 table %0d: entry[%0d]=%0d flag=%0b expected %0d flag=%0b",
                 t, TBL[t][12:7], ent_out[TBL[t][12:7]*EW +: EW], out_of_range,
                 TBL[t][6:1], TBL[t][0]);
      end
      model(ramp, int'(TBL[t][25:20]), int'(TBL[t][19:14]), TBL[t][13], exp_v, exp_f);
      check_vec("R4 table full", exp_v, exp_f);
    end

    // Every source, distance and direction with fresh random data.
    for (int s = 0; s < 64; s++) begin
      for (int d = 0; d < 64; d++) begin
        for (int dn = 0; dn < 2; dn++) begin
          for (int k = 0; k < N; k++) rnd[k*EW +: EW] = EW'($urandom);
          apply(rnd, s, d, bit'(dn));
          model(rnd, s, d, bit'(dn), exp_v, exp_f);
          if (exp_f)       check_vec("R5 sweep", exp_v, exp_f);
          else if (d == 0) check_vec("R1 sweep", exp_v, exp_f);
          else if (dn == 0) check_vec("R2 R4 R6 sweep", exp_v, exp_f);
          else             check_vec("R3 R4 R6 sweep", exp_v, exp_f);
        end
      end
    end

    // R7: data change alone, between edges, shows at once.
    apply(ramp, 10, 5, 1'b0);
    model(ramp, 10, 5, 1'b0, exp_v, exp_f);
    check_vec("R7 before", exp_v, exp_f);
    #1;
    ent_in = ~ramp;
    #1;
    model(~ramp, 10, 5, 1'b0, exp_v, exp_f);
    check_vec("R7 after", exp_v, exp_f);

    finish_run();
  end

endmodule